// File: doc/BRIEF.md
# I2C Serial Clock and Data-Edge Timing Generator

This block produces the serial clock of an I2C master and marks the cycle in which the data line may change. All timing is counted in cycles of the controller clock. Standard speed and fast speed each have their own pair of counts: one for the high phase and one for the low phase. A single mode input chooses which pair is active. Short counts are raised to fixed minimums. Within each low phase, a one-cycle data-change strobe is placed after a programmable hold delay. The strobe is pulled earlier when a programmable setup time before the next rising edge requires it.

The protocol sequencer holds the bit request high for as long as it has bits to send. Each falling clock edge raises a one-cycle bit tick so that the sequencer can advance. The sequencer uses the data-change strobe to update its data output. The block reads back the actual bus clock level. The high phase counts only while that level is high, so a slave that holds the clock low stretches the bit without shortening its high time. When enable is low, the clock is released and all counting restarts from the beginning.

Top module: `scl_timing_gen`

## Requirements
- R1: While `rst` is high or `enable` is low, `scl_out` is 1 (released) and `bit_tick` and `sda_strobe` are 0. The effect of `enable` going low appears at the next clock edge, including in the middle of a bit. After the block is enabled again, a new bit starts with a full low phase.
- R2: `fast_mode`=0 selects the standard-speed pair (`std_hi_cnt`, `std_lo_cnt`). `fast_mode`=1 selects the fast-speed pair (`fast_hi_cnt`, `fast_lo_cnt`).
- R3: Each low phase lasts exactly L cycles of `scl_out`=0, where L = max(selected low count, 8).
- R4: Each high phase lasts H cycles in which the observed bus clock `scl_in` is high, where H = max(selected high count, 6).
- R5: While `scl_in` is low during a high phase, the high count does not advance. A stretch of N cycles lengthens the bit period by exactly N cycles.
- R6: `bit_tick` is 1 for exactly the first cycle of every low phase, that is, once per falling edge of `scl_out`.
- R7: `hold_cfg` bit 8 enables the hold delay and bits 7:0 hold the count h. When bit 8 is set, `sda_strobe` fires in low-phase cycle h+1, counting from 0. When bit 8 is clear, it fires in cycle 0.
- R8: With setup count s on `setup_cnt`, the strobe position is limited to at most L − max(s−1, 1), and never below 0. So a large setup time pulls the strobe earlier than the hold delay asks for.
- R9: If `bit_req` is high when a high phase completes, the next low phase starts in the following cycle. If it is low, the block goes idle with `scl_out` high. While idle, a high `bit_req` starts a low phase at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Bus enable; low releases the clock and clears the counters |
| fast_mode | input | 1 | 0 = standard-speed counts, 1 = fast-speed counts |
| std_hi_cnt | input | CNT_W | Standard-speed high phase count |
| std_lo_cnt | input | CNT_W | Standard-speed low phase count |
| fast_hi_cnt | input | CNT_W | Fast-speed high phase count |
| fast_lo_cnt | input | CNT_W | Fast-speed low phase count |
| hold_cfg | input | DLY_W+1 | Bit DLY_W is the hold enable; lower bits are the hold count |
| setup_cnt | input | DLY_W | Data setup count before the rising edge |
| bit_req | input | 1 | Request to clock out another bit |
| scl_in | input | 1 | Observed level of the bus clock line |
| scl_out | output | 1 | 1 = release clock line, 0 = drive it low |
| sda_strobe | output | 1 | One-cycle strobe marking where data may change |
| bit_tick | output | 1 | One-cycle pulse at each falling clock edge |

## Verification
The generator is driven with several setups:
- A single bit in standard mode.
- Counts below both minimums, which shows that the clamps are applied.
- Fast mode with a distinct standard pair loaded, which shows that the right pair is chosen.
- Hold and setup values placed so that each one in turn decides the strobe position, plus an extreme setup value that drives the position to 0.

A slave stretch in the middle of the high phase separates counting of observed high cycles from counting of clock cycles. It shows up as an exact lengthening of the tick-to-tick period. A run of back-to-back bits, a drop of enable in the middle of the low phase, and a restart afterwards separate continuous operation from the return to idle and from the abort.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;

    // Floors applied to the programmed phase counts
    localparam int unsigned MIN_HIGH = 6;
    localparam int unsigned MIN_LOW  = 8;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

    // Per-cycle events leaving the phase machine
    typedef struct packed {
        logic scl_rel;   // clock line released
        logic tick;      // first cycle of a low phase
        logic chg;       // data may change in this cycle
    } line_ev_t;

    function automatic int unsigned at_least(int unsigned v, int unsigned floor_v);
        return (v < floor_v) ? floor_v : v;
    endfunction

endpackage

// File: rtl/sclgen_period_sel.sv
module sclgen_period_sel
    import sclgen_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             fast_mode,
    input  logic [CNT_W-1:0] std_hi,
    input  logic [CNT_W-1:0] std_lo,
    input  logic [CNT_W-1:0] fast_hi,
    input  logic [CNT_W-1:0] fast_lo,
    output logic [CNT_W-1:0] hi_eff,
    output logic [CNT_W-1:0] lo_eff
);

    logic [CNT_W-1:0] raw_hi;
    logic [CNT_W-1:0] raw_lo;

    always_comb begin
        raw_hi = fast_mode ? fast_hi : std_hi;
        raw_lo = fast_mode ? fast_lo : std_lo;
        hi_eff = CNT_W'(at_least(32'(raw_hi), MIN_HIGH));
        lo_eff = CNT_W'(at_least(32'(raw_lo), MIN_LOW));
    end

endmodule

// File: rtl/sclgen_sda_place.sv
module sclgen_sda_place #(
    parameter int CNT_W = 16,
    parameter int DLY_W = 8
) (
    input  logic [CNT_W-1:0] lo_eff,
    input  logic [DLY_W:0]   hold_cfg,
    input  logic [DLY_W-1:0] setup_cnt,
    output logic [CNT_W-1:0] chg_pos
);

    localparam int XW = CNT_W + 1;

    logic [XW-1:0] hold_pos;
    logic [XW-1:0] setup_gap;
    logic [XW-1:0] latest;
    logic [XW-1:0] pos;
    logic [XW-1:0] lo_x;

    always_comb begin
        lo_x = XW'(lo_eff);
        // hold: (count + 1) cycles after the fall when enabled, else none
        if (hold_cfg[DLY_W])
            hold_pos = XW'(hold_cfg[DLY_W-1:0]) + XW'(1);
        else
            hold_pos = '0;
        // setup: (count - 1) cycles before the rise, at least one cycle kept
        if (setup_cnt <= DLY_W'(2))
            setup_gap = XW'(1);
        else
            setup_gap = XW'(setup_cnt) - XW'(1);
        latest = (lo_x > setup_gap) ? (lo_x - setup_gap) : '0;
        pos    = (hold_pos < latest) ? hold_pos : latest;
        chg_pos = CNT_W'(pos);
    end

endmodule

// File: rtl/sclgen_phase_fsm.sv
module sclgen_phase_fsm
    import sclgen_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             bit_req,
    input  logic             scl_in,
    input  logic [CNT_W-1:0] hi_eff,
    input  logic [CNT_W-1:0] lo_eff,
    input  logic [CNT_W-1:0] chg_pos,
    output line_ev_t         ev
);

    phase_e           phase;
    logic [CNT_W-1:0] cnt;
    logic             low_done;
    logic             high_done;

    assign low_done  = (cnt == lo_eff - CNT_W'(1));
    assign high_done = (cnt == hi_eff - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (bit_req) begin
                        phase <= PH_LOW;
                        cnt   <= '0;
                    end
                end
                PH_LOW: begin
                    if (low_done) begin
                        phase <= PH_HIGH;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                PH_HIGH: begin
                    // count only cycles in which the line is really high
                    if (scl_in) begin
                        if (high_done) begin
                            phase <= bit_req ? PH_LOW : PH_IDLE;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                end
                default: begin
                    phase <= PH_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    always_comb begin
        ev.scl_rel = (phase != PH_LOW);
        ev.tick    = (phase == PH_LOW) && (cnt == '0);
        ev.chg     = (phase == PH_LOW) && (cnt == chg_pos);
    end

    // R1: a dropped enable releases the line at the next edge
    assert_disable_release_R1: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (phase == PH_IDLE) && (cnt == '0));

    // R5: stretched high phase freezes the count
    assert_stretch_freeze_R5: assert property (@(posedge clk) disable iff (rst)
        (enable && phase == PH_HIGH && !scl_in) |=> (phase == PH_HIGH) && $stable(cnt));

    // R3: low phase never runs past its effective length
    assert_low_bounded_R3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_LOW) |-> (cnt < lo_eff));

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import sclgen_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             fast_mode,
    input  logic [CNT_W-1:0] std_hi_cnt,
    input  logic [CNT_W-1:0] std_lo_cnt,
    input  logic [CNT_W-1:0] fast_hi_cnt,
    input  logic [CNT_W-1:0] fast_lo_cnt,
    input  logic [DLY_W:0]   hold_cfg,
    input  logic [DLY_W-1:0] setup_cnt,
    input  logic             bit_req,
    input  logic             scl_in,
    output logic             scl_out,
    output logic             sda_strobe,
    output logic             bit_tick
);

    logic [CNT_W-1:0] hi_eff;
    logic [CNT_W-1:0] lo_eff;
    logic [CNT_W-1:0] chg_pos;
    line_ev_t         ev;

    sclgen_period_sel #(.CNT_W(CNT_W)) u_period (
        .fast_mode (fast_mode),
        .std_hi    (std_hi_cnt),
        .std_lo    (std_lo_cnt),
        .fast_hi   (fast_hi_cnt),
        .fast_lo   (fast_lo_cnt),
        .hi_eff    (hi_eff),
        .lo_eff    (lo_eff)
    );

    sclgen_sda_place #(.CNT_W(CNT_W), .DLY_W(DLY_W)) u_place (
        .lo_eff    (lo_eff),
        .hold_cfg  (hold_cfg),
        .setup_cnt (setup_cnt),
        .chg_pos   (chg_pos)
    );

    sclgen_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .enable  (enable),
        .bit_req (bit_req),
        .scl_in  (scl_in),
        .hi_eff  (hi_eff),
        .lo_eff  (lo_eff),
        .chg_pos (chg_pos),
        .ev      (ev)
    );

    assign scl_out    = ev.scl_rel;
    assign sda_strobe = ev.chg;
    assign bit_tick   = ev.tick;

    // R6: every falling edge carries a tick, and a tick only on a fall
    assert_tick_on_fall_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(scl_out) |-> bit_tick);
    assert_tick_only_fall_R6: assert property (@(posedge clk) disable iff (rst)
        bit_tick |-> $fell(scl_out));

    // R7: data changes only while the clock is held low
    assert_strobe_in_low_R7: assert property (@(posedge clk) disable iff (rst)
        sda_strobe |-> !scl_out);

endmodule

// File: tb/test_scl_timing_gen.sv
module test_scl_timing_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        fast = 1'b0;
    logic [15:0] shi = 16'd10, slo = 16'd10, fhi = 16'd10, flo = 16'd10;
    logic [8:0]  hold_cfg = 9'd0;
    logic [7:0]  setup = 8'd0;
    logic        req = 1'b0;
    logic        stretch = 1'b0;
    logic        scl_out, sda_strobe, bit_tick;
    logic        scl_line;

    assign scl_line = scl_out & ~stretch;

    always #4 clk = ~clk;

    scl_timing_gen i_scl_timing_gen (
        .clk(clk), .rst(rst), .enable(en), .fast_mode(fast),
        .std_hi_cnt(shi), .std_lo_cnt(slo), .fast_hi_cnt(fhi), .fast_lo_cnt(flo),
        .hold_cfg(hold_cfg), .setup_cnt(setup), .bit_req(req), .scl_in(scl_line),
        .scl_out(scl_out), .sda_strobe(sda_strobe), .bit_tick(bit_tick)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // ---------- behavioural reference ----------
    function automatic int eff_low();
        int v = fast ? int'(flo) : int'(slo);
        return (v < 8) ? 8 : v;
    endfunction
    function automatic int eff_high();
        int v = fast ? int'(fhi) : int'(shi);
        return (v < 6) ? 6 : v;
    endfunction
    function automatic int exp_pos();
        int l = eff_low();
        int h = hold_cfg[8] ? int'(hold_cfg[7:0]) + 1 : 0;
        int s = (setup == 0) ? 0 : int'(setup) - 1;
        int lim = l - ((s < 1) ? 1 : s);
        if (lim < 0) lim = 0;
        return (h < lim) ? h : lim;
    endfunction

    int mph = 0;   // 0 idle, 1 low, 2 high
    int mlow = 0;  // low cycles already spent
    int mhigh = 0; // observed high cycles already spent

    always @(posedge clk) begin
        if (rst || !en) begin
            mph = 0; mlow = 0; mhigh = 0;
        end else if (mph == 0) begin
            if (req) begin mph = 1; mlow = 0; end
        end else if (mph == 1) begin
            mlow++;
            if (mlow == eff_low()) begin mph = 2; mhigh = 0; end
        end else begin
            if ((mph != 1) && !stretch) begin
                mhigh++;
                if (mhigh == eff_high()) begin
                    if (req) begin mph = 1; mlow = 0; end
                    else mph = 0;
                end
            end
        end
    end

    // ---------- per-cycle compare and monitor ----------
    int low_run = 0, last_low = 0, strobe_at = -1;
    int tick_cnt = 0, last_tick_cyc = 0, period = 0;

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            check(scl_out == (mph != 1), (mph == 1) ? "R3" : ((mph == 2) ? "R4" : "R1"),
                  int'(scl_out), int'(mph != 1));
            check(bit_tick == (mph == 1 && mlow == 0), "R6",
                  int'(bit_tick), int'(mph == 1 && mlow == 0));
            check(sda_strobe == (mph == 1 && mlow == exp_pos()), "R7",
                  int'(sda_strobe), int'(mph == 1 && mlow == exp_pos()));
        end
        if (!scl_out) begin
            if (sda_strobe) strobe_at = low_run;
            low_run++;
        end else if (low_run > 0) begin
            last_low = low_run;
            low_run = 0;
        end
        if (bit_tick) begin
            period = cyc - last_tick_cyc;
            last_tick_cyc = cyc;
            tick_cnt++;
        end
    end

    // ---------- stimulus helpers ----------
    task automatic step(input int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic cfg(input bit f, input int sh, input int sl, input int fh, input int fl,
                       input int hc, input int su);
        step(); en = 1'b0;
        fast = f; shi = 16'(sh); slo = 16'(sl); fhi = 16'(fh); flo = 16'(fl);
        hold_cfg = 9'(hc); setup = 8'(su);
        step(); en = 1'b1;
        step();
    endtask

    task automatic wait_ticks(input int n);
        int start = tick_cnt;
        while (tick_cnt < start + n) begin
            @(negedge clk); #1;
        end
    endtask

    task automatic run_bits(input int n);
        req = 1'b1;
        wait_ticks(n);
        step(); req = 1'b0;
        step(80);
    endtask

    // ---------- watchdog ----------
    initial begin
        #800000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int t0;
        // R1 reset state
        step(3);
        @(negedge clk);
        check(scl_out == 1'b1, "R1 reset scl", int'(scl_out), 1);
        check(bit_tick == 1'b0 && sda_strobe == 1'b0, "R1 reset strobes",
              int'(bit_tick) + int'(sda_strobe), 0);
        step(); rst = 1'b0;

        // A: standard single bit, hold decides strobe (R3, R7)
        cfg(0, 7, 10, 30, 30, 9'h100 | 2, 3);
        step(5);
        @(negedge clk);
        check(scl_out == 1'b1, "R9 idle without request", int'(scl_out), 1);
        step();
        run_bits(1);
        check(last_low == 10, "R3 low length", last_low, 10);
        check(strobe_at == 3, "R7 hold position", strobe_at, 3);

        // B: clamps, hold disabled (R3, R4, R7)
        cfg(0, 2, 3, 30, 30, 9'h0FF, 1);
        run_bits(2);
        check(last_low == 8, "R3 low clamp", last_low, 8);
        check(period == 14, "R4 high clamp period", period, 14);
        check(strobe_at == 0, "R7 hold disabled", strobe_at, 0);

        // C: fast pair chosen over standard pair (R2)
        cfg(1, 20, 20, 9, 12, 9'h100 | 4, 0);
        run_bits(2);
        check(last_low == 12, "R2 fast low", last_low, 12);
        check(period == 21, "R2 fast period", period, 21);
        check(strobe_at == 5, "R7 fast hold", strobe_at, 5);

        // D: setup limits strobe (R8)
        cfg(0, 7, 10, 30, 30, 9'h100 | 8, 5);
        run_bits(1);
        check(strobe_at == 6, "R8 setup pulls earlier", strobe_at, 6);
        cfg(0, 7, 10, 30, 30, 9'h100 | 8, 0);
        run_bits(1);
        check(strobe_at == 9, "R8 setup zero", strobe_at, 9);
        cfg(0, 7, 8, 30, 30, 9'h100 | 3, 255);
        run_bits(1);
        check(strobe_at == 0, "R8 setup max floors to 0", strobe_at, 0);

        // E: clock stretching (R5)
        cfg(0, 7, 10, 30, 30, 9'h0, 0);
        req = 1'b1;
        wait_ticks(1);
        while (scl_out == 1'b0) begin @(negedge clk); #1; end
        step(2); stretch = 1'b1;
        step(5); stretch = 1'b0;
        wait_ticks(1);
        step(); req = 1'b0;
        step(80);
        check(period == 22, "R5 stretch lengthens period", period, 22);

        // F: back-to-back bits (R9)
        cfg(0, 2, 3, 30, 30, 9'h0, 0);
        t0 = tick_cnt;
        req = 1'b1;
        wait_ticks(4);
        step(); req = 1'b0;
        step(80);
        check(tick_cnt - t0 == 4, "R9 tick count", tick_cnt - t0, 4);
        check(period == 14, "R9 continuous period", period, 14);

        // G: disable during low phase (R1)
        cfg(0, 7, 10, 30, 30, 9'h0, 0);
        req = 1'b1;
        wait_ticks(1);
        step(); en = 1'b0;
        step();
        @(negedge clk);
        check(scl_out == 1'b1, "R1 abort releases clock", int'(scl_out), 1);
        req = 1'b0;
        step(3); en = 1'b1;
        step(2);
        run_bits(1);
        check(last_low == 10, "R1 restart full low", last_low, 10);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule